// File: doc/BRIEF.md
# Bidirectional AES Byte Substitution Unit

This block is a purely combinational byte substitution unit for AES datapaths. A single select input decides whether the 8-bit input byte goes through the forward substitution (encryption) or the inverse substitution (decryption). The result appears on the output in the same cycle, with no clock and no stored state.

The logic is split into three stages:

- **Entry linear stage.** It depends on the direction. In the inverse direction it removes the AES affine mapping first. In the forward direction it passes the byte through unchanged.
- **Shared nonlinear core.** It computes the multiplicative inverse in GF(2^8), with zero mapped to zero. Both directions use it unchanged.
- **Exit linear stage.** It also depends on the direction. In the forward direction it applies the affine mapping. In the inverse direction it passes the core result through.

Each affine constant is folded into the linear trees. Bit positions whose constant bit is one use XNOR at their output, and all other positions use XOR.

Field arithmetic uses the reduction polynomial x^8+x^4+x^3+x+1.

- **Forward affine mapping.** Output bit i is the XOR of input bits i, i+4, i+5, i+6 and i+7 (indices mod 8), then XOR with constant 0x63.
- **Inverse affine mapping.** Output bit i is the XOR of bits i+2, i+5 and i+7 (mod 8), then XOR with constant 0x05.

Top module: `sbox_bidir`

## Requirements
- R1: With `dir_inv` = 0, `byte_out` equals the forward affine mapping applied to the GF(2^8) inverse of `byte_in`, for all 256 input values.
- R2: With `dir_inv` = 1, `byte_out` equals the GF(2^8) inverse of the inverse affine mapping of `byte_in`, for all 256 input values.
- R3: In the forward direction, input 0x00 gives output 0x63.
- R4: In the inverse direction, input 0x63 gives output 0x00.
- R5: For every byte x, feeding the forward result of x back in the inverse direction returns x.
- R6: The output depends only on the present values of `byte_in` and `dir_inv`. Toggling `dir_inv` while `byte_in` is held switches `byte_out` between the two mappings within the same cycle.
- R7: The shared core maps 0 to 0. For any nonzero operand it produces a value whose field product with the operand is 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_in | input | 8 | Byte to substitute |
| dir_inv | input | 1 | 0 selects forward substitution, 1 selects inverse substitution |
| byte_out | output | 8 | Substituted byte |

## Verification
The hardest condition to reach from the ports is a direction change with the data held constant. Every other sweep changes the byte and the direction together or keeps the direction fixed, so a stale multiplexer leg would stay hidden.

The stimulus covers this by holding a set of bytes, including 0x00, 0x63 and 0xFF, and flipping `dir_inv` on successive cycles. It also runs a round-trip sweep that drives every forward result back through the inverse path.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
    localparam int BW = 8;
    localparam logic [BW-1:0] RED_POLY = 8'h1B;

    function automatic logic [BW-1:0] gf_mul(input logic [BW-1:0] a, input logic [BW-1:0] b);
        logic [BW-1:0] acc;
        logic [BW-1:0] sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < BW; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = sh[BW-1] ? ({sh[BW-2:0], 1'b0} ^ RED_POLY) : {sh[BW-2:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [BW-1:0] gf_sq(input logic [BW-1:0] a);
        return gf_mul(a, a);
    endfunction
endpackage

// File: rtl/sbox_entry_lin.sv
module sbox_entry_lin
    import sbox_pkg::*;
#(
    parameter logic [7:0] REV_CONST = 8'h05
) (
    input  logic [BW-1:0] data_i,
    input  logic          inv_i,
    output logic [BW-1:0] oper_o
);
    localparam int TAP_A = 2;
    localparam int TAP_B = 5;
    localparam int TAP_C = 7;

    logic [BW-1:0] unmix;

    for (genvar i = 0; i < BW; i++) begin : g_unmix
        localparam int IA = (i + TAP_A) % BW;
        localparam int IB = (i + TAP_B) % BW;
        localparam int IC = (i + TAP_C) % BW;
        if (REV_CONST[i]) begin : g_xn
            assign unmix[i] = ~(data_i[IA] ^ data_i[IB] ^ data_i[IC]);
        end else begin : g_x
            assign unmix[i] = data_i[IA] ^ data_i[IB] ^ data_i[IC];
        end
    end

    assign oper_o = inv_i ? unmix : data_i;

    always_comb begin
        if (inv_i && data_i == 8'h63) begin
            p_unmix_zero_r4: assert (oper_o == 8'h00);
        end
    end
endmodule

// File: rtl/sbox_core_inv.sv
module sbox_core_inv
    import sbox_pkg::*;
(
    input  logic [BW-1:0] oper_i,
    output logic [BW-1:0] recip_o
);
    logic [BW-1:0] p2, p3, p12, p14, p15, p240;

    always_comb begin
        p2   = gf_sq(oper_i);
        p3   = gf_mul(p2, oper_i);
        p12  = gf_sq(gf_sq(p3));
        p14  = gf_mul(p12, p2);
        p15  = gf_mul(p12, p3);
        p240 = gf_sq(gf_sq(gf_sq(gf_sq(p15))));
        recip_o = gf_mul(p240, p14);
    end

    always_comb begin
        if (oper_i == '0) begin
            p_core_zero_r7: assert (recip_o == '0);
        end else begin
            p_core_unit_r7: assert (gf_mul(oper_i, recip_o) == 8'h01);
        end
    end
endmodule

// File: rtl/sbox_exit_lin.sv
module sbox_exit_lin
    import sbox_pkg::*;
#(
    parameter logic [7:0] FWD_CONST = 8'h63
) (
    input  logic [BW-1:0] recip_i,
    input  logic          inv_i,
    output logic [BW-1:0] data_o
);
    logic [BW-1:0] mixed;

    for (genvar i = 0; i < BW; i++) begin : g_mix
        localparam int I4 = (i + 4) % BW;
        localparam int I5 = (i + 5) % BW;
        localparam int I6 = (i + 6) % BW;
        localparam int I7 = (i + 7) % BW;
        if (FWD_CONST[i]) begin : g_xn
            assign mixed[i] = ~(recip_i[i] ^ recip_i[I4] ^ recip_i[I5] ^ recip_i[I6] ^ recip_i[I7]);
        end else begin : g_x
            assign mixed[i] = recip_i[i] ^ recip_i[I4] ^ recip_i[I5] ^ recip_i[I6] ^ recip_i[I7];
        end
    end

    assign data_o = inv_i ? recip_i : mixed;
endmodule

// File: rtl/sbox_bidir.sv
module sbox_bidir
    import sbox_pkg::*;
(
    input  logic [7:0] byte_in,
    input  logic       dir_inv,
    output logic [7:0] byte_out
);
    logic [BW-1:0] core_in;
    logic [BW-1:0] core_out;

    sbox_entry_lin #(.REV_CONST(8'h05)) u_entry (
        .data_i (byte_in),
        .inv_i  (dir_inv),
        .oper_o (core_in)
    );

    sbox_core_inv u_core (
        .oper_i  (core_in),
        .recip_o (core_out)
    );

    sbox_exit_lin #(.FWD_CONST(8'h63)) u_exit (
        .recip_i (core_out),
        .inv_i   (dir_inv),
        .data_o  (byte_out)
    );

    always_comb begin
        if (!dir_inv && byte_in == 8'h00) begin
            p_fwd_zero_r3: assert (byte_out == 8'h63);
        end
        if (dir_inv && byte_in == 8'h63) begin
            p_inv_zero_r4: assert (byte_out == 8'h00);
        end
        if (dir_inv) begin
            p_inv_passes_core_r2: assert (byte_out == core_out);
        end
    end
endmodule

// File: tb/sbox_bidir_tb.sv
module sbox_bidir_tb;
    logic       clk = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       dir_inv = 1'b0;
    logic [7:0] byte_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] stim;
        logic       dir;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    logic [7:0] fwd_tab[256];
    logic [7:0] inv_tab[256];

    always #10 clk = ~clk;

    sbox_bidir u_dut (
        .byte_in  (byte_in),
        .dir_inv  (dir_inv),
        .byte_out (byte_out)
    );

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] wide;
        wide = '0;
        for (int k = 0; k < 8; k++) if (a[k]) wide = wide ^ (16'(b) << k);
        for (int k = 15; k >= 8; k--) if (wide[k]) wide = wide ^ (16'h011B << (k - 8));
        return wide[7:0];
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] ref_inverse(input logic [7:0] a);
        if (a == 0) return 8'h00;
        for (int b = 1; b < 256; b++) if (ref_mul(a, 8'(b)) == 8'h01) return 8'(b);
        return 8'h00;
    endfunction

    task automatic drive(input logic d, input logic [7:0] v, input logic [7:0] e, input string r);
        item_t it;
        @(posedge clk);
        #2;
        dir_inv = d;
        byte_in = v;
        it.stim = v; it.dir = d; it.exp = e; it.req = r;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (byte_out !== it.exp) begin
                n_fail++;
                $display("FAIL %s: dir=%0b in=%02h actual=%02h expected=%02h",
                         it.req, it.dir, it.stim, byte_out, it.exp);
            end
        end
    end

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] b;
            b = ref_inverse(8'(x));
            fwd_tab[x] = b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
        end
        for (int x = 0; x < 256; x++) inv_tab[fwd_tab[x]] = 8'(x);

        // R3 / R4 corner values
        drive(1'b0, 8'h00, 8'h63, "R3");
        drive(1'b1, 8'h63, 8'h00, "R4");
        // R1 full forward sweep
        for (int x = 0; x < 256; x++) drive(1'b0, 8'(x), fwd_tab[x], "R1");
        // R2 full inverse sweep
        for (int x = 0; x < 256; x++) drive(1'b1, 8'(x), inv_tab[x], "R2");
        // R5 round trip through the inverse path
        for (int x = 0; x < 256; x++) drive(1'b1, fwd_tab[x], 8'(x), "R5");
        // R6 direction toggles with data held
        foreach (fwd_tab[k]) begin
            if (k % 37 == 0 || k == 8'h63 || k == 8'hFF) begin
                drive(1'b0, 8'(k), fwd_tab[k], "R6");
                drive(1'b1, 8'(k), inv_tab[k], "R6");
                drive(1'b0, 8'(k), fwd_tab[k], "R6");
            end
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule